// File: doc/BRIEF.md
# Pixel lane serializer for flat-panel links

This block turns one parallel pixel (red, green and blue of up to 10 bits each, plus horizontal sync, vertical sync and data-enable) into a seven-slot serial burst on up to five data lanes. A companion clock lane carries the pixel framing. The block runs entirely on the slot clock, which is seven times the pixel rate. A small slot sequencer steps through the seven slots of each pixel period. On the edge that leaves the last slot, it captures the next pixel and the mapping code together.

The pixel source watches `pix_take`. That output is high during slot 6, and the inputs present in that cycle are the ones taken at the next rising edge. The mapping code picks how color bits are spread over the lanes. In the 18-bit map, only three lanes carry data. In the "low-extension" maps, lanes 0 to 2 carry the upper color bits and the extra lanes carry the lowest bits. In the "high-extension" maps, lanes 0 to 2 carry bits 5:0 and the extra lanes carry the bits above them. The sync and enable bits sit in fixed slots of lane 2.

The sequencer states are `SL0` through `SL6`, one per slot. The only transitions are `SLk -> SLk+1` and the wrap `SL6 -> SL0`, which is the capture point. Reset places the sequencer in `SL6`.

Top module: `pix_lane_ser`

## Requirements
- R1: The slot index runs 0,1,...,6 and then wraps to 0, one step per slot clock. Slot 0 is sent first. `pix_take` is high exactly during slot 6. The inputs present in that cycle are captured at the rising edge that starts slot 0.
- R2: In slots 0 to 6, `lane_clk` takes the values 1,1,0,0,0,1,1.
- R3: With map code 0 (18-bit), the slots 0..6 carry these bits. Lane 0: G0, R5, R4, R3, R2, R1, R0. Lane 1: B1, B0, G5, G4, G3, G2, G1. Lane 2: DE, VS, HS, B5, B4, B3, B2. Lanes 3 and 4 stay low, and color bits 9:6 have no effect.
- R4: Lane 2 always carries DE in slot 0, VS in slot 1 and HS in slot 2. Slot 0 of lanes 3 and 4 is always 0.
- R5: Map code 1 (24-bit, low extension) uses the R3 layout on lanes 0 to 2, applied to color bits 7:2. Lane 3 carries 0, B1, B0, G1, G0, R1, R0 in slots 0..6. Lane 4 stays low, and bits 9:8 have no effect.
- R6: Map code 2 (30-bit, low extension) uses the R3 layout on bits 9:4. Lane 3 carries 0, B3, B2, G3, G2, R3, R2. Lane 4 carries 0, B1, B0, G1, G0, R1, R0.
- R7: Map code 3 (24-bit, high extension) uses the R3 layout on bits 5:0. Lane 3 carries 0, B7, B6, G7, G6, R7, R6. Lane 4 stays low, and bits 9:8 have no effect.
- R8: Map code 4 (30-bit, high extension) uses the R7 layout on lanes 0 to 3. Lane 4 carries 0, B9, B8, G9, G8, R9, R8.
- R9: Changes to the map code or the pixel inputs outside the capture cycle do not alter the pixel being sent. They take effect from the next slot 0.
- R10: Map codes 5, 6 and 7 behave exactly like map code 0.
- R11: While reset is held, the block sits in slot 6, all data lanes are low, `lane_clk` is high and `pix_take` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slot | input | 1 | Slot clock, seven cycles per pixel |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_r | input | 10 | Red component |
| pix_g | input | 10 | Green component |
| pix_b | input | 10 | Blue component |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| map_sel | input | 3 | Lane mapping code (0..4, 5..7 as 0) |
| pix_take | output | 1 | High in slot 6; inputs are captured at the next edge |
| lane_dat | output | 5 | Serial data lanes, bit n is lane n |
| lane_clk | output | 1 | Serial clock lane |

## Verification
Several properties are checked on every cycle by the assertions:
- the slot step and wrap;
- the edges of the clock lane falling in slots 2 and 5;
- `pix_take` sitting on a high clock-lane slot;
- slot 0 of the extension lanes being zero;
- lanes that are unused in the captured map staying low.

The exact placement of every color bit in every map cannot be expressed that way, so the bench's scenarios show it against an independent model. The same holds for the masking of unused high color bits, for reserved codes acting as the 18-bit map, and for changes after capture leaving the current pixel untouched.

// File: rtl/pls_pkg.sv
package pls_pkg;
    localparam int CW      = 10;
    localparam int NLANE   = 5;
    localparam int NSLOT   = 7;
    localparam int SLOT_W  = $clog2(NSLOT);
    localparam int SEL_W   = 3;

    typedef enum logic [SLOT_W-1:0] {
        SL0 = 3'd0, SL1 = 3'd1, SL2 = 3'd2, SL3 = 3'd3,
        SL4 = 3'd4, SL5 = 3'd5, SL6 = 3'd6
    } slot_e;

    typedef enum logic [SEL_W-1:0] {
        MAP_18   = 3'd0,
        MAP_LO24 = 3'd1,
        MAP_LO30 = 3'd2,
        MAP_HI24 = 3'd3,
        MAP_HI30 = 3'd4
    } map_e;

    typedef logic [NSLOT-1:0] lane_word_t;
endpackage

// File: rtl/pls_slot_fsm.sv
module pls_slot_fsm
    import pls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              load,
    output logic              clk_bit
);
    slot_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SL0: state_d = SL1;
            SL1: state_d = SL2;
            SL2: state_d = SL3;
            SL3: state_d = SL4;
            SL4: state_d = SL5;
            SL5: state_d = SL6;
            SL6: state_d = SL0;
            default: state_d = SL0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SL6;
        else        state_q <= state_d;
    end

    always_comb begin
        slot_idx = state_q;
        load     = 1'b0;
        clk_bit  = 1'b1;
        unique case (state_q)
            SL0, SL1:      clk_bit = 1'b1;
            SL2, SL3, SL4: clk_bit = 1'b0;
            SL5:           clk_bit = 1'b1;
            SL6: begin
                clk_bit = 1'b1;
                load    = 1'b1;
            end
            default:       clk_bit = 1'b1;
        endcase
    end
endmodule

// File: rtl/pls_lane_map.sv
module pls_lane_map
    import pls_pkg::*;
(
    input  logic [CW-1:0]    r,
    input  logic [CW-1:0]    g,
    input  logic [CW-1:0]    b,
    input  logic             hs,
    input  logic             vs,
    input  logic             de,
    input  logic [SEL_W-1:0] sel,
    output lane_word_t       words [NLANE]
);
    int  base;
    int  k3, k4;
    logic use3, use4;

    function automatic lane_word_t pair_word(logic [CW-1:0] rr, logic [CW-1:0] gg,
                                             logic [CW-1:0] bb, int lo);
        lane_word_t w;
        w[0] = 1'b0;
        w[1] = bb[lo+1];
        w[2] = bb[lo];
        w[3] = gg[lo+1];
        w[4] = gg[lo];
        w[5] = rr[lo+1];
        w[6] = rr[lo];
        return w;
    endfunction

    always_comb begin
        base = 0; k3 = 0; k4 = 0; use3 = 1'b0; use4 = 1'b0;
        case (sel)
            MAP_LO24: begin base = 2; k3 = 0; use3 = 1'b1; end
            MAP_LO30: begin base = 4; k3 = 2; k4 = 0; use3 = 1'b1; use4 = 1'b1; end
            MAP_HI24: begin base = 0; k3 = 6; use3 = 1'b1; end
            MAP_HI30: begin base = 0; k3 = 6; k4 = 8; use3 = 1'b1; use4 = 1'b1; end
            default:  begin base = 0; end
        endcase
    end

    always_comb begin
        words[0][0] = g[base];
        for (int s = 1; s < NSLOT; s++) words[0][s] = r[base+6-s];
        words[1][0] = b[base+1];
        words[1][1] = b[base];
        for (int s = 2; s < NSLOT; s++) words[1][s] = g[base+7-s];
        words[2][0] = de;
        words[2][1] = vs;
        words[2][2] = hs;
        for (int s = 3; s < NSLOT; s++) words[2][s] = b[base+8-s];
        words[3] = use3 ? pair_word(r, g, b, k3) : '0;
        words[4] = use4 ? pair_word(r, g, b, k4) : '0;
    end
endmodule

// File: rtl/pls_lane_out.sv
module pls_lane_out
    import pls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  lane_word_t        words_d [NLANE],
    input  logic [SLOT_W-1:0] slot_idx,
    output logic [NLANE-1:0]  lane_bits
);
    lane_word_t words_q [NLANE];

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    words_q[l] <= '0;
            else if (load) words_q[l] <= words_d[l];
        end
        assign lane_bits[l] = words_q[l][slot_idx];
    end
endmodule

// File: rtl/pix_lane_ser.sv
module pix_lane_ser
    import pls_pkg::*;
(
    input  logic             clk_slot,
    input  logic             rst_n,
    input  logic [CW-1:0]    pix_r,
    input  logic [CW-1:0]    pix_g,
    input  logic [CW-1:0]    pix_b,
    input  logic             pix_hs,
    input  logic             pix_vs,
    input  logic             pix_de,
    input  logic [SEL_W-1:0] map_sel,
    output logic             pix_take,
    output logic [NLANE-1:0] lane_dat,
    output logic             lane_clk
);
    logic [SLOT_W-1:0] slot_q;
    logic              load;
    lane_word_t        words_d [NLANE];

    pls_slot_fsm u_fsm (
        .clk      (clk_slot),
        .rst_n    (rst_n),
        .slot_idx (slot_q),
        .load     (load),
        .clk_bit  (lane_clk)
    );

    pls_lane_map u_map (
        .r     (pix_r),
        .g     (pix_g),
        .b     (pix_b),
        .hs    (pix_hs),
        .vs    (pix_vs),
        .de    (pix_de),
        .sel   (map_sel),
        .words (words_d)
    );

    pls_lane_out u_out (
        .clk       (clk_slot),
        .rst_n     (rst_n),
        .load      (load),
        .words_d   (words_d),
        .slot_idx  (slot_q),
        .lane_bits (lane_dat)
    );

    assign pix_take = load;
endmodule

// File: rtl/pls_checker.sv
module pls_checker
    import pls_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [SLOT_W-1:0] slot,
    input logic [SEL_W-1:0]  map_sel,
    input logic              pix_take,
    input logic [NLANE-1:0]  lane_dat,
    input logic              lane_clk
);
    logic [SEL_W-1:0] sel_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sel_seen <= '0;
        else if (pix_take) sel_seen <= map_sel;
    end

    a_r1_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == 3'd6) |=> (slot == 3'd0));
    a_r1_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (slot < 3'd6) |=> (slot == $past(slot) + 3'd1));
    a_r1_take_slot6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_take |-> (slot == 3'd6 && lane_clk));
    a_r2_clk_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lane_clk) |-> (slot == 3'd2));
    a_r2_clk_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_clk) |-> (slot == 3'd5));
    a_r4_ext_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == 3'd0) |-> (lane_dat[4:3] == 2'b00));
    a_r3_narrow_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_seen == 3'd0) |-> (lane_dat[4:3] == 2'b00));
    a_r10_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_seen > 3'd4) |-> (lane_dat[4:3] == 2'b00));
    a_r5_r7_lane4_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_seen == 3'd1 || sel_seen == 3'd3) |-> !lane_dat[4]);
endmodule

bind pix_lane_ser pls_checker u_chk (
    .clk      (clk_slot),
    .rst_n    (rst_n),
    .slot     (slot_q),
    .map_sel  (map_sel),
    .pix_take (pix_take),
    .lane_dat (lane_dat),
    .lane_clk (lane_clk)
);

// File: tb/test_pix_lane_ser.sv
`timescale 1ns/1ps
module test_pix_lane_ser;
    logic       clk_slot = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic       pix_hs = 0, pix_vs = 0, pix_de = 0;
    logic [2:0] map_sel = '0;
    logic       pix_take;
    logic [4:0] lane_dat;
    logic       lane_clk;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk_slot = ~clk_slot;

    pix_lane_ser i_pix_lane_ser (
        .clk_slot (clk_slot), .rst_n (rst_n),
        .pix_r (pix_r), .pix_g (pix_g), .pix_b (pix_b),
        .pix_hs (pix_hs), .pix_vs (pix_vs), .pix_de (pix_de),
        .map_sel (map_sel), .pix_take (pix_take),
        .lane_dat (lane_dat), .lane_clk (lane_clk)
    );

    function automatic logic exp_bit(int m, int ln, int s, logic [9:0] r, logic [9:0] g,
                                     logic [9:0] b, logic hs, logic vs, logic de);
        int top, p;
        if (m > 4) m = 0;
        top = (m == 1) ? 7 : (m == 2) ? 9 : 5;
        p = -1;
        case (ln)
            0: return (s == 0) ? g[top-5] : r[top-s+1];
            1: return (s == 0) ? b[top-4] : (s == 1) ? b[top-5] : g[top-s+2];
            2: return (s == 0) ? de : (s == 1) ? vs : (s == 2) ? hs : b[top-s+3];
            3: p = (m == 1) ? 1 : (m == 2) ? 3 : (m == 3 || m == 4) ? 7 : -1;
            default: p = (m == 2) ? 1 : (m == 4) ? 9 : -1;
        endcase
        if (p < 0) return 1'b0;
        case (s)
            1: return b[p];
            2: return b[p-1];
            3: return g[p];
            4: return g[p-1];
            5: return r[p];
            6: return r[p-1];
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // Sends one pixel; optionally disturbs map code and colors in slot 3 (R9).
    task automatic send_px(string req, int m, logic [9:0] r, logic [9:0] g, logic [9:0] b,
                           logic hs, logic vs, logic de, bit disturb);
        logic [34:0] exp_grid, got_grid;
        logic [6:0]  clk_got;
        logic [6:0]  take_got;
        while (pix_take !== 1'b1) @(negedge clk_slot);
        map_sel = 3'(m);
        pix_r = r; pix_g = g; pix_b = b; pix_hs = hs; pix_vs = vs; pix_de = de;
        for (int s = 0; s < 7; s++)
            for (int l = 0; l < 5; l++)
                exp_grid[s*5+l] = exp_bit(m, l, s, r, g, b, hs, vs, de);
        for (int s = 0; s < 7; s++) begin
            @(negedge clk_slot);
            for (int l = 0; l < 5; l++) got_grid[s*5+l] = lane_dat[l];
            clk_got[s]  = lane_clk;
            take_got[s] = pix_take;
            if (disturb && s == 3) begin
                map_sel = 3'((m + 2) % 5);
                pix_r = ~r; pix_g = ~g; pix_b = ~b;
                pix_hs = ~hs; pix_vs = ~vs; pix_de = ~de;
            end
        end
        check(req, 64'(got_grid), 64'(exp_grid));
        check("R2 clock lane", 64'(clk_got), 64'(7'b1100011));
        check("R1 take in slot 6", 64'(take_got), 64'(7'b1000000));
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk_slot);
        check("R11 reset lanes", 64'(lane_dat), 64'd0);
        check("R11 reset clk", 64'(lane_clk), 64'd1);
        check("R11 reset take", 64'(pix_take), 64'd1);
        rst_n = 1'b1;
    endtask

    task automatic t_map18;
        send_px("R3 map18 a", 0, 10'h02A, 10'h015, 10'h033, 1, 0, 1, 0);
        send_px("R3 map18 high bits ignored", 0, 10'h3C0 | 10'h02A, 10'h3C0 | 10'h015,
                10'h3C0 | 10'h033, 1, 0, 1, 0);
        send_px("R4 ctl slots", 0, 10'h000, 10'h000, 10'h000, 1, 1, 0, 0);
        send_px("R4 ctl de only", 0, 10'h3FF, 10'h3FF, 10'h3FF, 0, 0, 1, 0);
    endtask

    task automatic t_lo24;
        send_px("R5 lo24 a", 1, 10'h0A5, 10'h05A, 10'h0C3, 0, 1, 1, 0);
        send_px("R5 lo24 bits 9:8 ignored", 1, 10'h300 | 10'h081, 10'h342, 10'h3FF, 1, 0, 0, 0);
    endtask

    task automatic t_lo30;
        send_px("R6 lo30 a", 2, 10'h2B6, 10'h1C9, 10'h35A, 1, 1, 1, 0);
        send_px("R6 lo30 b", 2, 10'h00F, 10'h3F0, 10'h155, 0, 0, 0, 0);
    endtask

    task automatic t_hi24;
        send_px("R7 hi24 a", 3, 10'h0C3, 10'h081, 10'h07E, 1, 0, 1, 0);
        send_px("R7 hi24 bits 9:8 ignored", 3, 10'h3C3, 10'h381, 10'h27E, 0, 1, 0, 0);
    endtask

    task automatic t_hi30;
        send_px("R8 hi30 a", 4, 10'h2A9, 10'h156, 10'h301, 1, 1, 0, 0);
        send_px("R8 hi30 b", 4, 10'h1FE, 10'h203, 10'h0F0, 0, 0, 1, 0);
    endtask

    task automatic t_late_change;
        send_px("R9 late change ignored", 4, 10'h2A9, 10'h156, 10'h301, 1, 0, 1, 1);
        send_px("R9 new map at next pixel", 0, 10'h02A, 10'h015, 10'h033, 0, 1, 1, 0);
    endtask

    task automatic t_reserved;
        send_px("R10 code 5", 5, 10'h3AB, 10'h2CD, 10'h1EF, 1, 0, 1, 0);
        send_px("R10 code 7", 7, 10'h155, 10'h2AA, 10'h0F3, 0, 1, 0, 0);
    endtask

    initial begin
        t_reset();
        t_map18();
        t_lo24();
        t_lo30();
        t_hi24();
        t_hi30();
        t_late_change();
        t_reserved();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule